// File: doc/BRIEF.md
# Low-Power Stop and Wake Sequencer

This block decides which clock resources stay alive when the core executes a stop command, and how the system comes back when a wake request arrives. A configuration bit selects one of two depths. A deep stop switches off both the crystal oscillator enable and the PLL enable. A light stop leaves the oscillator and the PLL under their normal configuration and closes only the gate that feeds the clock divider and the core.

Recovery from a light stop is a fixed three-cycle delay. Recovery from a deep stop first restarts the oscillator and the PLL. It then counts either a short (16) or a long (65536) number of external clock cycles. If the PLL is enabled, it waits for the PLL to report lock. When recovery ends, the core clock gate reopens and a one-cycle ready pulse is issued.

Top module: `stop_seq`

## Requirements
- R1: Out of reset the block is running: `core_clk_en_o`=1, `ready_o`=0, `osc_en_o`=!`xtal_dis_i`, `pll_en_o`=`pll_en_i`.
- R2: `stop_i` sampled high while running, with `light_mode_i`=0, gives `osc_en_o`=0 and `pll_en_o`=0 from the next cycle until the wake request is sampled.
- R3: `stop_i` sampled high while running, with `light_mode_i`=1, keeps `osc_en_o`=!`xtal_dis_i` and `pll_en_o`=`pll_en_i` while stopped.
- R4: `core_clk_en_o` is 0 from the cycle after `stop_i` is accepted until the ready pulse, and `ready_o` stays 0 throughout.
- R5: After a light stop, the ready pulse (with `core_clk_en_o`=1) appears in the cycle following the third rising edge after the edge that sampled `wake_i` high.
- R6: After a deep stop with `pll_en_i`=0, the ready pulse follows the Nth edge after the wake edge, where N=16 for `long_rec_i`=0 and N=65536 for `long_rec_i`=1. `long_rec_i` is sampled at the wake edge.
- R7: After a deep stop with `pll_en_i`=1, the ready pulse follows the first edge at or after edge N+1 that samples `pll_lock_i` high.
- R8: `ready_o` is high for exactly one cycle, and the block then stays running with `core_clk_en_o`=1.
- R9: `wake_i` has no effect while running: `core_clk_en_o` stays 1 and `ready_o` stays 0.
- R10: During deep-stop recovery, `osc_en_o`=!`xtal_dis_i` and `pll_en_o`=`pll_en_i`, so that the sources restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Stop command strobe |
| wake_i | input | 1 | Wake request |
| light_mode_i | input | 1 | 1 = light stop, 0 = deep stop |
| long_rec_i | input | 1 | Deep recovery length: 1 = long, 0 = short |
| xtal_dis_i | input | 1 | Crystal oscillator disabled by configuration |
| pll_en_i | input | 1 | PLL enabled by configuration |
| pll_lock_i | input | 1 | PLL lock indication |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| core_clk_en_o | output | 1 | Core and divider clock gate enable |
| ready_o | output | 1 | One-cycle pulse when the core resumes |

## Verification
A stuck or wrongly chosen state shows up at the ports in the cycle right after the stop command. The oscillator and PLL enables then fail to match the selected depth, or the core gate fails to close. A miscounted or misloaded recovery counter moves the ready pulse by whole cycles, so every wake latency is measured exactly against a value computed from depth, recovery length, PLL enable and the cycle in which lock arrives. A missing lock wait, or a wait that never ends, shows as early or absent resumption.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOP_DEEP,
    ST_STOP_LIGHT,
    ST_REC_CNT,
    ST_WAIT_LOCK,
    ST_RESUME
  } seq_state_e;
endpackage

// File: rtl/stop_rec_counter.sv
module stop_rec_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  cnt_hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/stop_seq_fsm.sv
module stop_seq_fsm
  import stop_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_CNT = 16,
  parameter int LONG_CNT  = 65536,
  parameter int LIGHT_CNT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             wake_i,
  input  logic             light_mode_i,
  input  logic             long_rec_i,
  input  logic             xtal_dis_i,
  input  logic             pll_en_i,
  input  logic             pll_lock_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             core_clk_en_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CNT - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CNT - 1);
  localparam logic [CNT_W-1:0] LIGHT_LD = CNT_W'(LIGHT_CNT - 1);

  seq_state_e state_q, state_d;
  logic       deep_q, deep_d;
  logic       stopped;

  always_comb begin
    state_d    = state_q;
    deep_d     = deep_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = LIGHT_LD;
    unique case (state_q)
      ST_RUN: if (stop_i) begin
        state_d = light_mode_i ? ST_STOP_LIGHT : ST_STOP_DEEP;
        deep_d  = !light_mode_i;
      end
      ST_STOP_DEEP, ST_STOP_LIGHT: if (wake_i) begin
        state_d    = ST_REC_CNT;
        cnt_load_o = 1'b1;
        if (deep_q) cnt_val_o = long_rec_i ? LONG_LD : SHORT_LD;
      end
      ST_REC_CNT: if (cnt_zero_i)
        state_d = (deep_q && pll_en_i) ? ST_WAIT_LOCK : ST_RESUME;
      ST_WAIT_LOCK: if (pll_lock_i) state_d = ST_RESUME;
      ST_RESUME: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      deep_q  <= deep_d;
    end
  end

  // only a deep stop parks the sources; recovery restarts them
  assign osc_en_o      = (state_q != ST_STOP_DEEP) && !xtal_dis_i;
  assign pll_en_o      = (state_q != ST_STOP_DEEP) && pll_en_i;
  assign core_clk_en_o = (state_q == ST_RUN) || (state_q == ST_RESUME);
  assign ready_o       = (state_q == ST_RESUME);
  assign stopped       = (state_q == ST_STOP_DEEP) || (state_q == ST_STOP_LIGHT);

  // R4
  stop_gates_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_i) |=> !core_clk_en_o);

  // R4
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped && !wake_i) |=> (!core_clk_en_o && !ready_o));

  // R7
  lock_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_LOCK && !pll_lock_i) |=> !ready_o);

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (!ready_o && core_clk_en_o));

  // R9
  wake_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !stop_i) |=> (core_clk_en_o && !ready_o));

  // R2
  deep_sources_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_i && !light_mode_i) |=> (!osc_en_o && !pll_en_o));
endmodule

// File: rtl/stop_seq.sv
module stop_seq #(
  parameter int SHORT_CNT = 16,
  parameter int LONG_CNT  = 65536,
  parameter int LIGHT_CNT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic wake_i,
  input  logic light_mode_i,
  input  logic long_rec_i,
  input  logic xtal_dis_i,
  input  logic pll_en_i,
  input  logic pll_lock_i,
  output logic osc_en_o,
  output logic pll_en_o,
  output logic core_clk_en_o,
  output logic ready_o
);
  localparam int MAX_A = (SHORT_CNT > LONG_CNT) ? SHORT_CNT : LONG_CNT;
  localparam int MAX_CNT = (MAX_A > LIGHT_CNT) ? MAX_A : LIGHT_CNT;
  localparam int CNT_W = (MAX_CNT > 2) ? $clog2(MAX_CNT) : 1;

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  stop_seq_fsm #(
    .CNT_W    (CNT_W),
    .SHORT_CNT(SHORT_CNT),
    .LONG_CNT (LONG_CNT),
    .LIGHT_CNT(LIGHT_CNT)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_i       (stop_i),
    .wake_i       (wake_i),
    .light_mode_i (light_mode_i),
    .long_rec_i   (long_rec_i),
    .xtal_dis_i   (xtal_dis_i),
    .pll_en_i     (pll_en_i),
    .pll_lock_i   (pll_lock_i),
    .cnt_zero_i   (cnt_zero),
    .cnt_load_o   (cnt_load),
    .cnt_val_o    (cnt_val),
    .osc_en_o     (osc_en_o),
    .pll_en_o     (pll_en_o),
    .core_clk_en_o(core_clk_en_o),
    .ready_o      (ready_o)
  );

  stop_rec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .zero_o    (cnt_zero)
  );
endmodule

// File: tb/stop_seq_tb.sv
module stop_seq_tb;
  localparam int SHORT_N = 16;
  localparam int LONG_N  = 65536;
  localparam int LIGHT_N = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stop_i = 1'b0, wake_i = 1'b0, light_mode_i = 1'b0, long_rec_i = 1'b0;
  logic xtal_dis_i = 1'b0, pll_en_i = 1'b1, pll_lock_i = 1'b1;
  logic osc_en_o, pll_en_o, core_clk_en_o, ready_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  stop_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .stop_i(stop_i), .wake_i(wake_i),
    .light_mode_i(light_mode_i), .long_rec_i(long_rec_i), .xtal_dis_i(xtal_dis_i),
    .pll_en_i(pll_en_i), .pll_lock_i(pll_lock_i), .osc_en_o(osc_en_o),
    .pll_en_o(pll_en_o), .core_clk_en_o(core_clk_en_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input bit light, input bit lng, input bit pe, input int lock_at);
    int n;
    if (light) return LIGHT_N;
    n = lng ? LONG_N : SHORT_N;
    if (!pe) return n;
    return (lock_at + 1 > n + 1) ? lock_at + 1 : n + 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic episode(input bit light, input bit lng, input bit xd, input bit pe,
                         input int lock_at, input int idle);
    int k;
    int lat;
    bit early;
    light_mode_i = light;
    xtal_dis_i   = xd;
    pll_en_i     = pe;
    pll_lock_i   = light ? 1'b1 : (lock_at == 0);
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    chk(core_clk_en_o == 1'b0, "R4 core gate closed after stop", int'(core_clk_en_o), 0);
    if (light) begin
      chk(osc_en_o == !xd, "R3 light stop oscillator", int'(osc_en_o), int'(!xd));
      chk(pll_en_o == pe, "R3 light stop pll", int'(pll_en_o), int'(pe));
    end else begin
      chk(!osc_en_o && !pll_en_o, "R2 deep stop sources off",
          int'({osc_en_o, pll_en_o}), 0);
    end
    early = 1'b0;
    for (int i = 0; i < idle; i++) begin
      tick();
      if (core_clk_en_o || ready_o) early = 1'b1;
    end
    chk(!early, "R4 stays stopped without wake", int'(early), 0);
    long_rec_i = lng;
    wake_i = 1'b1;
    tick();
    wake_i = 1'b0;
    long_rec_i = ~lng;
    if (!light)
      chk(osc_en_o == !xd && pll_en_o == pe, "R10 deep recovery restarts sources",
          int'({osc_en_o, pll_en_o}), int'({!xd, pe}));
    k = 0;
    lat = -1;
    early = 1'b0;
    while (lat < 0 && k < LONG_N + 200) begin
      tick();
      k++;
      if (ready_o) lat = k;
      else begin
        if (core_clk_en_o) early = 1'b1;
        if (k == lock_at) pll_lock_i = 1'b1;
      end
    end
    chk(!early, "R4 core gate closed during recovery", int'(early), 0);
    chk(lat == exp_latency(light, lng, pe, lock_at),
        light ? "R5 light latency" : (pe ? "R7 deep lock latency" : "R6 deep count latency"),
        lat, exp_latency(light, lng, pe, lock_at));
    chk(core_clk_en_o == 1'b1, "R8 core gate open with ready", int'(core_clk_en_o), 1);
    tick();
    chk(!ready_o && core_clk_en_o, "R8 single ready pulse then run",
        int'({ready_o, core_clk_en_o}), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(core_clk_en_o && !ready_o, "R1 reset run state", int'({core_clk_en_o, ready_o}), 2);
    chk(osc_en_o && pll_en_o, "R1 reset sources", int'({osc_en_o, pll_en_o}), 3);

    // R9: wake while running
    wake_i = 1'b1;
    tick();
    tick();
    wake_i = 1'b0;
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 4; i++) begin
        if (!core_clk_en_o || ready_o) bad = 1'b1;
        tick();
      end
      chk(!bad, "R9 wake ignored while running", int'(bad), 0);
    end

    episode(1'b1, 1'b0, 1'b0, 1'b1, 0, 2);
    episode(1'b1, 1'b0, 1'b1, 1'b0, 0, 0);
    episode(1'b0, 1'b0, 1'b0, 1'b0, 0, 3);
    episode(1'b0, 1'b0, 1'b1, 1'b1, 0, 1);
    episode(1'b0, 1'b0, 1'b0, 1'b1, 30, 4);
    episode(1'b0, 1'b0, 1'b0, 1'b1, 17, 0);
    episode(1'b0, 1'b1, 1'b0, 1'b0, 0, 1);
    episode(1'b0, 1'b1, 1'b0, 1'b1, 5, 0);

    for (int e = 0; e < 20; e++) begin
      episode(1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), int'($urandom_range(0, 40)),
              int'($urandom_range(0, 10)));
      repeat (int'($urandom_range(0, 3))) tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule